// File: doc/BRIEF.md
# Autonegotiation Link Supervisor with Parallel-Detect Fallback

This block watches a hardware 1000BASE-X autonegotiation engine and decides when the port may be declared up. It runs on a periodic poll strobe. On each strobe it compares the control word it has applied to the engine with the word it wants. A mismatch starts a fresh negotiation, unless a parallel-detected link is still being trusted. When the words match, it grants the link on a completed negotiation and resolves the pause abilities of both ends. If negotiation stalls past a timeout, it switches the engine's negotiation off and waits a fixed number of clocks. It then grants the link by parallel detection if the line is in sync and carries no configuration words.

A down-counter, counted in poll strobes, times both the negotiation attempt and how long a parallel-detected link is trusted. A flag records that the current link came from parallel detection. With local autonegotiation disabled, the engine's negotiation is turned off and the link simply follows PCS sync.

Top module: `an_link_supervisor`

## Requirements
- R1: The pause pair written to the engine on a restart is taken from the flow-control requests: TX and RX gives symmetric=1 asymmetric=0; TX only gives 0/1; RX only gives 1/1; neither gives 0/0. engPause carries symmetric and engAsym carries asymmetric.
- R2: With anEnable low, a poll turns engAnOn off, sets linkUp to pcsSync and clears both advertisement outputs.
- R3: On a poll where the applied control word differs from the wanted one, the parallel-detect flag is set, the counter is nonzero, pcsSync is high and cfgRcvd is low, the counter decrements and linkUp stays high.
- R4: Any other control mismatch restarts negotiation. The wanted word is applied, softReset is high for the cycle after that edge, the counter loads the AN timeout, parallel detect clears and linkUp goes low.
- R5: With matching control and sync present, anDone gives linkUp. advLocal is then {engPause, engAsym}, advPartner is {lpPause, lpAsym}, and the counter is zeroed with parallel detect cleared. In every other outcome both advertisement outputs are zero.
- R6: With matching control, sync or signal detect present and anDone low, a poll with a nonzero counter decrements it and holds linkUp low.
- R7: The same poll with a zero counter turns engAnOn off at once. WAIT_CYC clocks later, pcsSync high with cfgRcvd low gives linkUp, sets parallel detect and loads the counter with the parallel-detect timeout.
- R8: If that resampling finds no sync, or finds configuration words, negotiation restarts as in R4.
- R9: With neither pcsSync nor sigDetect on a matching poll, the counter reloads the AN timeout, parallel detect clears and linkUp is low.
- R10: Whenever linkUp goes low, the parallel-detect flag clears, so a later control mismatch restarts instead of holding the link.
- R11: Poll strobes that arrive during the post-disable wait are ignored.
- R12: After reset engAnOn, engPause, engAsym, softReset, linkUp, advLocal and advPartner are all zero, and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pollTick | input | 1 | One-cycle poll strobe |
| pcsSync | input | 1 | PCS synchronisation acquired |
| sigDetect | input | 1 | Receive signal detected |
| cfgRcvd | input | 1 | Configuration code words being received |
| anDone | input | 1 | Engine reports negotiation complete |
| lpPause | input | 1 | Partner symmetric pause ability |
| lpAsym | input | 1 | Partner asymmetric pause ability |
| anEnable | input | 1 | Local autonegotiation wanted |
| fcTx | input | 1 | Local request to send pause frames |
| fcRx | input | 1 | Local request to honour pause frames |
| engAnOn | output | 1 | Engine control: negotiation enable |
| engPause | output | 1 | Engine control: symmetric pause advertised |
| engAsym | output | 1 | Engine control: asymmetric pause advertised |
| softReset | output | 1 | One-cycle engine soft-reset pulse |
| linkUp | output | 1 | Link declared up |
| advLocal | output | 2 | Resolved local pause bits {symmetric, asymmetric} |
| advPartner | output | 2 | Resolved partner pause bits {symmetric, asymmetric} |

## Verification
Most results register on the clock edge that samples the poll strobe, so they are due one clock after it. The one exception is the outcome of a timeout, which lands WAIT_CYC clocks after the edge that switched negotiation off. The bench holds a behavioural model that applies the same edge-by-edge timing and compares it with every output at each falling edge. The inputs change only on falling edges, so each comparison sees settled registered values. Directed checks after each poll read the outputs on the falling edge right after the sampling edge, which is the only time the one-cycle soft-reset pulse can be seen.

// File: rtl/an_sup_pkg.sv
package an_sup_pkg;

  typedef struct packed {
    logic restart;
    logic holdPd;
    logic disableAn;
    logic grantAn;
    logic countDown;
    logic startWait;
    logic pdGrant;
    logic noSignal;
    logic linkDown;
  } supStrobes_t;

  // {symmetric, asymmetric} from the TX/RX flow-control requests
  function automatic logic [1:0] pauseEncode(input logic tx, input logic rx);
    logic [1:0] enc;
    if (tx && rx)  enc = 2'b10;
    else if (tx)   enc = 2'b01;
    else if (rx)   enc = 2'b11;
    else           enc = 2'b00;
    return enc;
  endfunction

endpackage

// File: rtl/an_sup_ctrl.sv
module an_sup_ctrl
  import an_sup_pkg::*;
#(
  parameter int WAIT_CYC = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pollTick,
  input  logic        anEnable,
  input  logic        pcsSync,
  input  logic        sigDetect,
  input  logic        cfgRcvd,
  input  logic        anDone,
  input  logic        ctrlMatch,
  input  logic        cntZero,
  input  logic        pdFlag,
  output supStrobes_t strb
);
  localparam int WAIT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  typedef enum logic {ST_IDLE, ST_WAIT} supState_t;
  supState_t state;
  logic [WAIT_W-1:0] waitCnt;

  always_comb begin
    strb = '0;
    if (state == ST_WAIT) begin
      if (waitCnt == '0) begin
        if (pcsSync && !cfgRcvd) strb.pdGrant = 1'b1;
        else                     strb.restart = 1'b1;
      end
    end else if (pollTick) begin
      if (!anEnable) begin
        strb.disableAn = 1'b1;
      end else if (!ctrlMatch) begin
        if (pdFlag && !cntZero && pcsSync && !cfgRcvd) strb.holdPd  = 1'b1;
        else                                           strb.restart = 1'b1;
      end else if (pcsSync || sigDetect) begin
        if (anDone && pcsSync) strb.grantAn   = 1'b1;
        else if (!anDone)      begin
          if (cntZero) strb.startWait = 1'b1;
          else         strb.countDown = 1'b1;
        end else               strb.linkDown  = 1'b1;
      end else begin
        strb.noSignal = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else if (strb.startWait) begin
      state   <= ST_WAIT;
      waitCnt <= WAIT_W'(WAIT_CYC - 1);
    end else if (state == ST_WAIT) begin
      if (waitCnt == '0) state <= ST_IDLE;
      else               waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  // R11: a single action per cycle, so a strobe during the wait cannot add one
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R7: the wait window never exceeds its configured length
  a_r7_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (waitCnt <= WAIT_W'(WAIT_CYC - 1)));

endmodule

// File: rtl/an_sup_dp.sv
module an_sup_dp
  import an_sup_pkg::*;
#(
  parameter int AN_TO = 8,
  parameter int PD_TO = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  supStrobes_t strb,
  input  logic        anEnable,
  input  logic        fcTx,
  input  logic        fcRx,
  input  logic        pcsSync,
  input  logic        lpPause,
  input  logic        lpAsym,
  output logic [2:0]  engCtrl,
  output logic        softReset,
  output logic        linkUp,
  output logic [1:0]  advLocal,
  output logic [1:0]  advPartner,
  output logic        ctrlMatch,
  output logic        cntZero,
  output logic        pdFlag
);
  localparam int CNT_MAX = (AN_TO > PD_TO) ? AN_TO : PD_TO;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       wantCtrl;
  logic             linkNext;

  assign wantCtrl  = anEnable ? {1'b1, pauseEncode(fcTx, fcRx)} : 3'b000;
  assign ctrlMatch = (engCtrl == wantCtrl);
  assign cntZero   = (cnt == '0);

  always_comb begin
    linkNext = linkUp;
    if (strb.disableAn)                        linkNext = pcsSync;
    else if (strb.holdPd || strb.grantAn || strb.pdGrant) linkNext = 1'b1;
    else if (strb != '0)                       linkNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engCtrl    <= '0;
      softReset  <= 1'b0;
      linkUp     <= 1'b0;
      advLocal   <= '0;
      advPartner <= '0;
      cnt        <= '0;
      pdFlag     <= 1'b0;
    end else begin
      softReset <= 1'b0;
      linkUp    <= linkNext;
      if (strb != '0) begin
        advLocal   <= '0;
        advPartner <= '0;
      end
      if (strb.restart) begin
        engCtrl   <= wantCtrl;
        softReset <= 1'b1;
        cnt       <= CNT_W'(AN_TO);
      end
      if (strb.disableAn || strb.startWait) engCtrl <= 3'b000;
      if (strb.holdPd || strb.countDown)    cnt <= cnt - CNT_W'(1);
      if (strb.noSignal)                    cnt <= CNT_W'(AN_TO);
      if (strb.grantAn) begin
        cnt        <= '0;
        advLocal   <= engCtrl[1:0];
        advPartner <= {lpPause, lpAsym};
      end
      if (strb.pdGrant) begin
        cnt    <= CNT_W'(PD_TO);
        pdFlag <= 1'b1;
      end else if (strb.restart || strb.grantAn || strb.noSignal || !linkNext) begin
        pdFlag <= 1'b0;
      end
    end
  end

  // R4: a soft-reset pulse comes with a fresh AN timeout and a dropped link
  a_r4_restart_loads: assert property (@(posedge clk) disable iff (!rstN)
    softReset |-> (cnt == CNT_W'(AN_TO) && !pdFlag && !linkUp));

  // R10: a parallel-detect flag never outlives the link
  a_r10_pd_needs_link: assert property (@(posedge clk) disable iff (!rstN)
    pdFlag |-> linkUp);

  // R5: resolved pause bits appear only on a live link
  a_r5_adv_with_link: assert property (@(posedge clk) disable iff (!rstN)
    ((advLocal != 2'b00) || (advPartner != 2'b00)) |-> linkUp);

  // R6: the counter stays within the larger timeout
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/an_link_supervisor.sv
module an_link_supervisor
  import an_sup_pkg::*;
#(
  parameter int AN_TO    = 8,
  parameter int PD_TO    = 4,
  parameter int WAIT_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pollTick,
  input  logic       pcsSync,
  input  logic       sigDetect,
  input  logic       cfgRcvd,
  input  logic       anDone,
  input  logic       lpPause,
  input  logic       lpAsym,
  input  logic       anEnable,
  input  logic       fcTx,
  input  logic       fcRx,
  output logic       engAnOn,
  output logic       engPause,
  output logic       engAsym,
  output logic       softReset,
  output logic       linkUp,
  output logic [1:0] advLocal,
  output logic [1:0] advPartner
);
  supStrobes_t strb;
  logic [2:0]  engCtrl;
  logic        ctrlMatch, cntZero, pdFlag;

  an_sup_ctrl #(.WAIT_CYC(WAIT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .pollTick(pollTick), .anEnable(anEnable),
    .pcsSync(pcsSync), .sigDetect(sigDetect), .cfgRcvd(cfgRcvd),
    .anDone(anDone), .ctrlMatch(ctrlMatch), .cntZero(cntZero),
    .pdFlag(pdFlag), .strb(strb)
  );

  an_sup_dp #(.AN_TO(AN_TO), .PD_TO(PD_TO)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .anEnable(anEnable),
    .fcTx(fcTx), .fcRx(fcRx), .pcsSync(pcsSync), .lpPause(lpPause),
    .lpAsym(lpAsym), .engCtrl(engCtrl), .softReset(softReset),
    .linkUp(linkUp), .advLocal(advLocal), .advPartner(advPartner),
    .ctrlMatch(ctrlMatch), .cntZero(cntZero), .pdFlag(pdFlag)
  );

  assign {engAnOn, engPause, engAsym} = engCtrl;

  // R2: a poll with negotiation unwanted leaves the engine's negotiation off
  a_r2_disable_off: assert property (@(posedge clk) disable iff (!rstN)
    (pollTick && !anEnable && !strb.restart && !strb.pdGrant) |=> !engAnOn);

endmodule

// File: tb/sim_an_link_supervisor.sv
module sim_an_link_supervisor;
  localparam int AN_TO = 8, PD_TO = 4, WAIT_CYC = 3;

  logic clk = 1'b0;
  logic rstN;
  logic pollTick, pcsSync, sigDetect, cfgRcvd, anDone, lpPause, lpAsym;
  logic anEnable, fcTx, fcRx;
  logic engAnOn, engPause, engAsym, softReset, linkUp;
  logic [1:0] advLocal, advPartner;

  int nChecks = 0, nFail = 0;
  bit cmpOn = 0, done = 0;
  string curReq = "R12";
  logic srSeen;

  always #10 clk = ~clk;

  an_link_supervisor #(.AN_TO(AN_TO), .PD_TO(PD_TO), .WAIT_CYC(WAIT_CYC)) u0 (
    .clk(clk), .rstN(rstN), .pollTick(pollTick), .pcsSync(pcsSync),
    .sigDetect(sigDetect), .cfgRcvd(cfgRcvd), .anDone(anDone),
    .lpPause(lpPause), .lpAsym(lpAsym), .anEnable(anEnable), .fcTx(fcTx),
    .fcRx(fcRx), .engAnOn(engAnOn), .engPause(engPause), .engAsym(engAsym),
    .softReset(softReset), .linkUp(linkUp), .advLocal(advLocal),
    .advPartner(advPartner)
  );

  // behavioural reference state
  logic [2:0] mCtrl = '0;
  logic [1:0] mAdvL = '0, mAdvR = '0;
  bit mSr = 0, mLink = 0, mPd = 0, mWait = 0;
  int mCnt = 0, mWaitLeft = 0;

  function automatic logic [2:0] wanted();
    logic [1:0] p;
    case ({fcTx, fcRx})
      2'b11: p = 2'b10;
      2'b10: p = 2'b01;
      2'b01: p = 2'b11;
      default: p = 2'b00;
    endcase
    return anEnable ? {1'b1, p} : 3'b000;
  endfunction

  task automatic mRestart();
    mCtrl = wanted(); mSr = 1; mCnt = AN_TO; mPd = 0; mLink = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mAdvL = 0; mAdvR = 0; mSr = 0; mLink = 0; mPd = 0;
      mWait = 0; mCnt = 0; mWaitLeft = 0;
    end else begin
      mSr = 0;
      if (mWait) begin
        if (mWaitLeft == 0) begin
          mWait = 0; mAdvL = 0; mAdvR = 0;
          if (pcsSync && !cfgRcvd) begin mLink = 1; mPd = 1; mCnt = PD_TO; end
          else mRestart();
        end else mWaitLeft--;
      end else if (pollTick) begin
        mAdvL = 0; mAdvR = 0;
        if (!anEnable) begin
          mCtrl = 0; mLink = pcsSync;
        end else if (mCtrl != wanted()) begin
          if (mPd && mCnt != 0 && pcsSync && !cfgRcvd) begin mCnt--; mLink = 1; end
          else mRestart();
        end else if (pcsSync || sigDetect) begin
          if (anDone && pcsSync) begin
            mLink = 1; mCnt = 0; mPd = 0;
            mAdvL = mCtrl[1:0]; mAdvR = {lpPause, lpAsym};
          end else if (!anDone) begin
            mLink = 0;
            if (mCnt != 0) mCnt--;
            else begin mCtrl = 0; mWait = 1; mWaitLeft = WAIT_CYC - 1; end
          end else mLink = 0;
        end else begin
          mCnt = AN_TO; mPd = 0; mLink = 0;
        end
      end
      if (!mLink) mPd = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn)
      chk(curReq, {21'd0, engAnOn, engPause, engAsym, softReset, linkUp, advLocal, advPartner},
                  {21'd0, mCtrl, mSr, mLink, mAdvL, mAdvR});
  end

  task automatic poll();
    pollTick = 1'b1;
    @(negedge clk);
    pollTick = 1'b0;
    srSeen = softReset;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pollTick = 0; pcsSync = 0; sigDetect = 0; cfgRcvd = 0;
    anDone = 0; lpPause = 0; lpAsym = 0; anEnable = 0; fcTx = 0; fcRx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", {engAnOn, engPause, engAsym, softReset, linkUp, advLocal, advPartner}, 0);

    curReq = "R2";
    pcsSync = 1; poll();
    chk("R2", {engAnOn, linkUp, advLocal, advPartner}, 6'b010000);
    pcsSync = 0; poll();
    chk("R2", linkUp, 0);

    curReq = "R1";
    anEnable = 1; fcTx = 1; fcRx = 1; poll();
    chk("R4", {srSeen, linkUp}, 2'b10);
    chk("R1", {engAnOn, engPause, engAsym}, 3'b110);
    fcRx = 0; poll();
    chk("R1", {engAnOn, engPause, engAsym}, 3'b101);
    fcTx = 0; fcRx = 1; poll();
    chk("R1", {engAnOn, engPause, engAsym}, 3'b111);
    fcRx = 0; poll();
    chk("R1", {engAnOn, engPause, engAsym}, 3'b100);
    fcTx = 1; fcRx = 1; poll();
    chk("R1", {engAnOn, engPause, engAsym}, 3'b110);

    curReq = "R5";
    pcsSync = 1; sigDetect = 1; anDone = 1; lpPause = 0; lpAsym = 1; poll();
    chk("R5", {linkUp, advLocal, advPartner}, 5'b11001);

    curReq = "R9";
    pcsSync = 0; sigDetect = 0; anDone = 0; poll();
    chk("R9", {linkUp, advLocal, advPartner}, 0);

    curReq = "R6";
    pcsSync = 1; sigDetect = 1; cfgRcvd = 1;
    for (int i = 0; i < AN_TO; i++) begin
      poll();
      chk("R6", {engAnOn, linkUp, srSeen}, 3'b100);
    end

    curReq = "R8";
    poll();
    chk("R7", engAnOn, 0);
    repeat (3) @(negedge clk);
    chk("R8", {engAnOn, linkUp}, 2'b10);

    curReq = "R7";
    for (int i = 0; i < AN_TO; i++) poll();
    cfgRcvd = 0; poll();
    chk("R7", engAnOn, 0);
    curReq = "R11";
    pollTick = 1; @(negedge clk); pollTick = 0;
    repeat (3) @(negedge clk);
    chk("R11", engAnOn, 0);
    chk("R7", {linkUp, advLocal, advPartner}, 5'b10000);

    curReq = "R3";
    for (int i = 0; i < PD_TO; i++) begin
      poll();
      chk("R3", {linkUp, engAnOn, srSeen}, 3'b100);
    end
    poll();
    chk("R4", {srSeen, linkUp, engAnOn}, 3'b101);

    curReq = "R10";
    for (int i = 0; i < AN_TO; i++) poll();
    poll();
    repeat (3) @(negedge clk);
    chk("R10", linkUp, 1);
    anEnable = 0; pcsSync = 0; poll();
    chk("R10", linkUp, 0);
    anEnable = 1; pcsSync = 1; poll();
    chk("R10", {srSeen, linkUp}, 2'b10);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule